// File: doc/BRIEF.md
# Identifier Code Reader

This block sits on the programmer side of a byte-wide UV-erasable memory socket and fetches the two identifier bytes that the part presents before it is programmed. On a start pulse it raises an identifier-mode request (the programmer's high-voltage driver uses it to lift the designated address line to the elevated level). It drives chip enable and output enable low, holds every address bit except bit 0 low, and reads byte 0 (A0 low) and then byte 1 (A0 high). After each change of A0 it waits a programmable number of clock cycles before it samples the data bus.

Byte 0 is the manufacturer code and byte 1 the device code. Both are latched and checked for odd parity, with bit 7 acting as the parity bit. They are then compared against expected values. A temperature-window enable must stay true for the whole sequence; if it drops, the reader releases the part and reports an abort. A completed or aborted run is signalled by a one-cycle done pulse. The results are held until the next start.

Top module: `idcode_reader`

## Requirements
- R1: After reset, hv_req_o is 0, ce_n_o and oe_n_o are 1, dev_addr_o is 0, done_o and abort_o are 0, both codes are 0x00, and par_err_o and match_o are 0.
- R2: While hv_req_o is 1, ce_n_o and oe_n_o are 0 and every bit of dev_addr_o above bit 0 is 0.
- R3: The reader first drives dev_addr_o[0]=0 and latches that byte into mfr_code_o. It then drives dev_addr_o[0]=1 and latches that byte into dev_code_o.
- R4: Each A0 phase lasts exactly access_dly_i+1 cycles, and the bus is sampled on the clock edge that ends the phase.
- R5: A byte passes parity when its 8 bits hold an odd number of ones (bit 7 is the parity bit). par_err_o is 1 when either byte fails.
- R6: match_o is 1 only when both bytes pass parity, mfr_code_o equals 0x89 and dev_code_o equals EXP_DEV (default 0x83).
- R7: done_o pulses for exactly one cycle when byte 1 has been sampled. In that same cycle hv_req_o is 0 and ce_n_o and oe_n_o are 1.
- R8: If temp_ok_i is 0 at start or during the mode, the reader drops hv_req_o on the next cycle, pulses done_o, and sets abort_o=1 and match_o=0.
- R9: A start pulse while the mode is active is ignored: the phase lengths and the single done pulse are unchanged.
- R10: A parity failure does not stop the sequence: both bytes are still read, done_o pulses, and match_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an identifier read |
| temp_ok_i | input | 1 | Ambient temperature within programming window |
| access_dly_i | input | DLY_W | Cycles to wait after each A0 change, minus one |
| dev_data_i | input | 8 | Data bus from the memory part |
| hv_req_o | output | 1 | Identifier-mode (elevated voltage) request |
| dev_addr_o | output | ADDR_W | Address to the part |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | Last run aborted by temperature window |
| mfr_code_o | output | 8 | Latched byte 0 |
| dev_code_o | output | 8 | Latched byte 1 |
| par_err_o | output | 1 | Either byte failed odd parity |
| match_o | output | 1 | Both codes valid and as expected |

## Verification
Some properties are checked by assertions on every cycle. Enables and the upper address bits stay low throughout the mode. A0 can only rise while the mode is active. Done is a single-cycle pulse. A match never coexists with a parity error. Losing the temperature window drops the mode request on the next cycle. The delay counter never wraps below zero. Other behaviour can only be shown by the bench scenarios, with a part model that returns valid data only after the phase has lasted the programmed delay. These scenarios cover exact phase lengths, which byte lands in which code register, the parity and comparison outcomes for good, swapped, mismatched and even-parity bytes, and ignored restarts.

// File: rtl/idr_pkg.sv
package idr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE0 = 2'd1,
        ST_BYTE1 = 2'd2
    } idr_state_e;

    typedef struct packed {
        idr_state_e        st;
        logic              a0;
        logic              done;
        logic              abort;
        logic [BYTE_W-1:0] mfr;
        logic [BYTE_W-1:0] dev;
        logic              perr;
        logic              match;
    } idr_regs_t;
endpackage

// File: rtl/idr_delay_timer.sv
module idr_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - DLY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/idr_parity_chk.sv
module idr_parity_chk
    import idr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ok_o
);
    // Odd parity over all bits; bit 7 is the parity bit.
    assign ok_o = ^byte_i;
endmodule

// File: rtl/idcode_reader.sv
module idcode_reader
    import idr_pkg::*;
#(
    parameter int               ADDR_W  = 14,
    parameter int               DLY_W   = 8,
    parameter logic [BYTE_W-1:0] EXP_MFR = 8'h89,
    parameter logic [BYTE_W-1:0] EXP_DEV = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              temp_ok_i,
    input  logic [DLY_W-1:0]  access_dly_i,
    input  logic [BYTE_W-1:0] dev_data_i,
    output logic              hv_req_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              done_o,
    output logic              abort_o,
    output logic [BYTE_W-1:0] mfr_code_o,
    output logic [BYTE_W-1:0] dev_code_o,
    output logic              par_err_o,
    output logic              match_o
);
    localparam int NBYTES = 2;

    idr_regs_t r_d, r_q;
    logic      tmr_load, tmr_zero;
    logic [BYTE_W-1:0] chk_byte [NBYTES];
    logic [NBYTES-1:0] par_ok;

    idr_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (access_dly_i),
        .zero_o     (tmr_zero)
    );

    // Byte 0 is checked from its latch, byte 1 straight off the bus.
    assign chk_byte[0] = r_q.mfr;
    assign chk_byte[1] = dev_data_i;

    for (genvar g = 0; g < NBYTES; g++) begin : g_par
        idr_parity_chk u_par (
            .byte_i (chk_byte[g]),
            .ok_o   (par_ok[g])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.mfr   = '0;
                    r_d.dev   = '0;
                    r_d.perr  = 1'b0;
                    r_d.match = 1'b0;
                    r_d.a0    = 1'b0;
                    if (temp_ok_i) begin
                        r_d.abort = 1'b0;
                        r_d.st    = ST_BYTE0;
                        tmr_load  = 1'b1;
                    end else begin
                        r_d.abort = 1'b1;
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_BYTE0: begin
                if (!temp_ok_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.a0    = 1'b0;
                    r_d.abort = 1'b1;
                    r_d.done  = 1'b1;
                end else if (tmr_zero) begin
                    r_d.mfr  = dev_data_i;
                    r_d.a0   = 1'b1;
                    r_d.st   = ST_BYTE1;
                    tmr_load = 1'b1;
                end
            end
            ST_BYTE1: begin
                if (!temp_ok_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.a0    = 1'b0;
                    r_d.abort = 1'b1;
                    r_d.done  = 1'b1;
                end else if (tmr_zero) begin
                    r_d.dev   = dev_data_i;
                    r_d.a0    = 1'b0;
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.perr  = ~&par_ok;
                    r_d.match = (&par_ok) && (r_q.mfr == EXP_MFR)
                                && (dev_data_i == EXP_DEV);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign hv_req_o   = (r_q.st != ST_IDLE);
    assign ce_n_o     = ~hv_req_o;
    assign oe_n_o     = ~hv_req_o;
    assign dev_addr_o = {{(ADDR_W-1){1'b0}}, r_q.a0};
    assign done_o     = r_q.done;
    assign abort_o    = r_q.abort;
    assign mfr_code_o = r_q.mfr;
    assign dev_code_o = r_q.dev;
    assign par_err_o  = r_q.perr;
    assign match_o    = r_q.match;

    AST_MODE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        hv_req_o |-> (!ce_n_o && !oe_n_o && dev_addr_o[ADDR_W-1:1] == '0)); // R2
    AST_A0_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_addr_o[0]) |-> $past(hv_req_o)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hv_req_o); // R7
    AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> !par_err_o); // R6
    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_req_o && !temp_ok_i) |=> (!hv_req_o && abort_o)); // R8
endmodule

// File: tb/tb_idcode_reader.sv
module tb_idcode_reader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       temp_ok = 1'b1;
    logic [7:0] dly = 8'd0;
    logic [7:0] bus;
    logic       hv, ce_n, oe_n, done, abort_f, perr, match;
    logic [13:0] addr;
    logic [7:0] mfr, devc;

    logic [7:0] mfr_b = 8'h89, dev_b = 8'h83;
    int ph0 = 0, ph1 = 0, viol = 0, done_cnt = 0;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    idcode_reader dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .temp_ok_i(temp_ok),
        .access_dly_i(dly), .dev_data_i(bus), .hv_req_o(hv),
        .dev_addr_o(addr), .ce_n_o(ce_n), .oe_n_o(oe_n), .done_o(done),
        .abort_o(abort_f), .mfr_code_o(mfr), .dev_code_o(devc),
        .par_err_o(perr), .match_o(match)
    );

    // Part model: data valid only once the current phase has lasted dly+1 cycles.
    always_comb begin
        bus = 8'h00;
        if (hv && !ce_n && !oe_n) begin
            if (!addr[0] && ph0 >= int'(dly) + 1) bus = mfr_b;
            if ( addr[0] && ph1 >= int'(dly) + 1) bus = dev_b;
        end
    end

    always @(negedge clk) begin
        if (hv) begin
            if (!addr[0]) ph0 = ph0 + 1;
            else          ph1 = ph1 + 1;
            if (ce_n || oe_n || addr[13:1] != 13'd0) viol = viol + 1;
        end
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ph0 = 0; ph1 = 0; viol = 0; done_cnt = 0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R7 done seen", done, 1);
        chk(!hv && ce_n && oe_n, "R7 released at done", hv, 0);
    endtask

    task automatic run_read(input logic [7:0] m, input logic [7:0] d, input int dl,
                            input bit e_perr, input bit e_match, input bit restart);
        mfr_b = m; dev_b = d; dly = 8'(dl);
        @(negedge clk);
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        @(negedge clk);
        chk(ph0 == dl + 1, "R4 phase0 length", ph0, dl + 1);
        chk(ph1 == dl + 1, "R4 phase1 length", ph1, dl + 1);
        chk(viol == 0, "R2 enables/address in mode", viol, 0);
        chk(mfr == m, "R3 manufacturer byte", mfr, m);
        chk(devc == d, "R3 device byte", devc, d);
        chk(perr == e_perr, "R5 parity flag", perr, e_perr);
        chk(match == e_match, "R6 match flag", match, e_match);
        chk(abort_f == 1'b0, "R8 no abort", abort_f, 0);
        chk(done_cnt == 1, "R7/R9 single done", done_cnt, 1);
        if (restart) chk(hv == 1'b0, "R9 restart ignored", hv, 0);
    endtask

    task automatic test_reset();
        chk(!hv && ce_n && oe_n && addr == 14'd0, "R1 idle pins", {hv, ce_n, oe_n}, 3'b011);
        chk(!done && !abort_f && !perr && !match, "R1 flags", {done, abort_f, perr, match}, 0);
        chk(mfr == 8'h00 && devc == 8'h00, "R1 codes", {mfr, devc}, 0);
    endtask

    task automatic test_abort_start();
        temp_ok = 1'b0;
        @(negedge clk);
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R8 abort at start done", done, 1);
        chk(abort_f == 1'b1, "R8 abort flag", abort_f, 1);
        @(negedge clk);
        chk(ph0 == 0 && ph1 == 0, "R8 no mode entered", ph0 + ph1, 0);
        chk(match == 1'b0, "R8 no match", match, 0);
        temp_ok = 1'b1;
    endtask

    task automatic test_abort_mid();
        dly = 8'd6; mfr_b = 8'h89; dev_b = 8'h83;
        @(negedge clk);
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(hv == 1'b1, "R8 mode active before abort", hv, 1);
        temp_ok = 1'b0;
        @(negedge clk);
        chk(hv == 1'b0, "R8 mode dropped", hv, 0);
        chk(done == 1'b1 && abort_f == 1'b1, "R8 done+abort", {done, abort_f}, 3);
        chk(match == 1'b0, "R8 match low", match, 0);
        temp_ok = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_read(8'h89, 8'h83, 3, 1'b0, 1'b1, 1'b0);   // R3 R6 good pair
        run_read(8'h89, 8'h83, 0, 1'b0, 1'b1, 1'b0);   // R4 zero delay
        run_read(8'h89, 8'h83, 10, 1'b0, 1'b1, 1'b0);  // R4 long delay
        run_read(8'h8A, 8'h83, 2, 1'b0, 1'b0, 1'b0);   // R6 wrong manufacturer, parity ok
        run_read(8'h83, 8'h89, 2, 1'b0, 1'b0, 1'b0);   // R3 swapped bytes
        run_read(8'h89, 8'h82, 2, 1'b1, 1'b0, 1'b0);   // R5 R10 device byte even parity
        run_read(8'h88, 8'h83, 1, 1'b1, 1'b0, 1'b0);   // R5 R10 manufacturer even parity
        run_read(8'h89, 8'h83, 5, 1'b0, 1'b1, 1'b1);   // R9 restart mid-run
        test_abort_start();                             // R8
        test_abort_mid();                               // R8
        run_read(8'h89, 8'h83, 1, 1'b0, 1'b1, 1'b0);   // R8 recovers after abort
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule